// File: doc/BRIEF.md
# Routed Level Interrupt Controller

This block gathers up to thirty-two level-sensitive interrupt lines from peripherals and decides which of them reach the processor. An enable mask gates each source. A pending source then drives one of several processor interrupt request lines. Which line it drives depends on a 4-bit steering code kept per source. The codes are packed eight to a 32-bit register.

Software reaches the block through a plain single-cycle 32-bit register port. Read data is registered. Besides the request lines, the block exposes the pending vector (enable AND raw level). It also gives the index of the lowest-numbered pending source with a valid flag, so a handler can service sources in find-first-set order without scanning. Sources are level-sensitive: a source stays pending for as long as its input is held high and its enable bit is set. No edge is latched.

Top module: `lirq_router`

## Requirements
- R1: After reset the enable mask and all four steering registers are zero, so `irq_pending`, `cpu_irq`, `first_vld` and `bus_rdata` are all zero.
- R2: The enable mask sits at byte offset 0x00 and is fully readable and writable. Bit s enables source s.
- R3: Offset 0x04 reads the present raw level of `src_level`. A write to 0x04 changes nothing.
- R4: Four steering registers sit at offsets 0x08, 0x0C, 0x10 and 0x14, and each is fully readable and writable. Source s uses index k = 31 - s. Its 4-bit code lies in register 0x08 + 4*(k/8), at bits [31-4*(k%8) -: 4]. Source 31 therefore uses 0x08[31:28], source 24 uses 0x08[3:0], source 23 uses 0x0C[31:28], and source 0 uses 0x14[3:0].
- R5: `irq_pending` equals mask AND `src_level`. It follows the inputs in the same cycle and has no memory of earlier levels.
- R6: A source with code n, where 1 <= n <= 6, drives `cpu_irq[n-1]`. Each `cpu_irq` bit is the OR of all pending sources whose code selects it.
- R7: A code of 0 and codes 7 through 15 drive no `cpu_irq` line.
- R8: `first_idx` gives the lowest bit number set in `irq_pending`, and `first_vld` is high exactly when `irq_pending` is non-zero.
- R9: A read of any other offset returns zero, including offsets that are not word-aligned. A write to any other offset changes no register.
- R10: Read data appears on `bus_rdata` after the clock edge that samples the read, and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| src_level | input | 32 | Raw peripheral interrupt levels |
| irq_pending | output | 32 | Mask AND raw level |
| cpu_irq | output | 6 | Processor interrupt request lines |
| first_idx | output | 5 | Lowest pending source number |
| first_vld | output | 1 | Some source is pending |

## Verification
Two things can land on the same clock edge. One is a mask or steering write. The other is a change of `src_level`, or a read of the status offset while the level moves. The bench provokes both by randomising the source levels on the very negedge where it drives a register access. It then checks the pending vector, the request lines and the lowest-index output against a reference model that applies the write first. It also checks that a status read returns the level that was present at the sampling edge.

// File: rtl/lirq_pkg.sv
package lirq_pkg;

  localparam int unsigned WORD_W = 32;

  localparam logic [7:0] OFF_MASK = 8'h00;
  localparam logic [7:0] OFF_STAT = 8'h04;
  localparam logic [7:0] OFF_RT0  = 8'h08;

  // Flat bit offset of the steering code for source s, given code width cw
  // and total source count ns (highest source occupies the top field of the
  // first steering word).
  function automatic int unsigned code_base(input int unsigned s,
                                            input int unsigned ns,
                                            input int unsigned cw);
    int unsigned k;
    int unsigned fpr;
    fpr = WORD_W / cw;
    k   = ns - 1 - s;
    return (k / fpr) * WORD_W + (fpr - 1 - (k % fpr)) * cw;
  endfunction

endpackage

// File: rtl/lirq_regs.sv
module lirq_regs
  import lirq_pkg::*;
#(
  parameter int unsigned NSRC = 32,
  parameter int unsigned CW   = 4,
  parameter int unsigned AW   = 8,
  localparam int unsigned NRT = (NSRC * CW + WORD_W - 1) / WORD_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_sel,
  input  logic                  bus_wr,
  input  logic [AW-1:0]         bus_addr,
  input  logic [WORD_W-1:0]     bus_wdata,
  input  logic [NSRC-1:0]       src_level,
  output logic [WORD_W-1:0]     bus_rdata,
  output logic [NSRC-1:0]       mask_q,
  output logic [NRT*WORD_W-1:0] route_flat
);

  logic                 wr_en;
  logic                 rd_en;
  logic                 hit_mask;
  logic                 hit_stat;
  logic [NRT-1:0]       hit_rt;
  logic [NSRC-1:0]      mask_d;
  logic [WORD_W-1:0]    route_q [NRT];
  logic [WORD_W-1:0]    route_d [NRT];
  logic [WORD_W-1:0]    rd_d;
  logic [WORD_W-1:0]    rdata_q;

  assign wr_en    = bus_sel & bus_wr;
  assign rd_en    = bus_sel & ~bus_wr;
  assign hit_mask = (bus_addr == AW'(OFF_MASK));
  assign hit_stat = (bus_addr == AW'(OFF_STAT));

  // Mask register
  always_comb begin
    mask_d = mask_q;
    if (wr_en && hit_mask) mask_d = bus_wdata[NSRC-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  // Steering registers
  for (genvar r = 0; r < NRT; r++) begin : g_rt
    assign hit_rt[r] = (bus_addr == AW'(OFF_RT0 + 8'(4 * r)));

    always_comb begin
      route_d[r] = route_q[r];
      if (wr_en && hit_rt[r]) route_d[r] = bus_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) route_q[r] <= '0;
      else        route_q[r] <= route_d[r];
    end

    assign route_flat[r*WORD_W +: WORD_W] = route_q[r];
  end

  // Read path
  always_comb begin
    rd_d = '0;
    if (hit_mask) rd_d[NSRC-1:0] = mask_q;
    if (hit_stat) rd_d[NSRC-1:0] = src_level;
    for (int r = 0; r < NRT; r++) begin
      if (hit_rt[r]) rd_d = route_q[r];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_d;
  end

  assign bus_rdata = rdata_q;

  // R2: mask changes only through a write to its offset
  p_mask_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_wr && bus_addr == AW'(OFF_MASK)) |=> $stable(mask_q));

  // R3: status read returns the level seen at the sampling edge
  p_stat_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == AW'(OFF_STAT))
      |=> bus_rdata[NSRC-1:0] == $past(src_level));

  // R9: unmapped reads return zero
  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && !hit_mask && !hit_stat && hit_rt == '0)
      |=> bus_rdata == '0);

  // R10: read data holds when no read is sampled
  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && !bus_wr) |=> $stable(bus_rdata));

endmodule

// File: rtl/lirq_steer.sv
module lirq_steer
  import lirq_pkg::*;
#(
  parameter int unsigned NSRC = 32,
  parameter int unsigned CW   = 4,
  parameter int unsigned NCPU = 6,
  localparam int unsigned NRT = (NSRC * CW + WORD_W - 1) / WORD_W
) (
  input  logic [NSRC-1:0]       pending,
  input  logic [NRT*WORD_W-1:0] route_flat,
  output logic [NCPU-1:0]       cpu_irq
);

  logic [CW-1:0] code [NSRC];

  for (genvar s = 0; s < NSRC; s++) begin : g_code
    localparam int unsigned BASE = code_base(s, NSRC, CW);
    assign code[s] = route_flat[BASE +: CW];
  end

  // Codes 0 and above NCPU never match a line index.
  always_comb begin
    cpu_irq = '0;
    for (int k = 0; k < NCPU; k++) begin
      for (int s = 0; s < NSRC; s++) begin
        if (pending[s] && code[s] == CW'(k + 1)) cpu_irq[k] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/lirq_ffs.sv
module lirq_ffs #(
  parameter int unsigned NSRC = 32,
  localparam int unsigned IW  = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] pend,
  output logic [IW-1:0]   idx,
  output logic            vld
);

  always_comb begin
    idx = '0;
    vld = 1'b0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pend[i]) begin
        idx = IW'(i);
        vld = 1'b1;
      end
    end
  end

  // R8: the reported source is really pending
  p_ffs_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vld |-> pend[idx]);

  // R8: nothing below the reported source is pending
  p_ffs_lowest_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vld |-> (pend & ((NSRC'(1) << idx) - NSRC'(1))) == '0);

  // R8: no valid flag while nothing is pending
  p_ffs_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0) |-> !vld);

endmodule

// File: rtl/lirq_router.sv
module lirq_router
  import lirq_pkg::*;
#(
  parameter int unsigned NSRC = 32,
  parameter int unsigned CW   = 4,
  parameter int unsigned NCPU = 6,
  parameter int unsigned AW   = 8,
  localparam int unsigned NRT = (NSRC * CW + WORD_W - 1) / WORD_W,
  localparam int unsigned IW  = $clog2(NSRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [AW-1:0]     bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic [NSRC-1:0]   src_level,
  output logic [NSRC-1:0]   irq_pending,
  output logic [NCPU-1:0]   cpu_irq,
  output logic [IW-1:0]     first_idx,
  output logic              first_vld
);

  logic [NSRC-1:0]       mask_q;
  logic [NRT*WORD_W-1:0] route_flat;

  lirq_regs #(.NSRC(NSRC), .CW(CW), .AW(AW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .src_level  (src_level),
    .bus_rdata  (bus_rdata),
    .mask_q     (mask_q),
    .route_flat (route_flat)
  );

  assign irq_pending = mask_q & src_level;

  lirq_steer #(.NSRC(NSRC), .CW(CW), .NCPU(NCPU)) u_steer (
    .pending    (irq_pending),
    .route_flat (route_flat),
    .cpu_irq    (cpu_irq)
  );

  lirq_ffs #(.NSRC(NSRC)) u_ffs (
    .clk   (clk),
    .rst_n (rst_n),
    .pend  (irq_pending),
    .idx   (first_idx),
    .vld   (first_vld)
  );

  // R6: no request line without a pending source
  p_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pending == '0) |-> (cpu_irq == '0));

  // R5: a source whose level is low is never pending
  p_level_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pending & ~src_level) == '0);

endmodule

// File: tb/lirq_router_tb.sv
`timescale 1ns/1ps
module lirq_router_tb_top;

  logic        clk;
  logic        rst_n;
  logic        bus_sel;
  logic        bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [31:0] src_level;
  logic [31:0] irq_pending;
  logic [5:0]  cpu_irq;
  logic [4:0]  first_idx;
  logic        first_vld;

  int n_run;
  int n_fail;
  logic [31:0] m_mask;
  logic [31:0] m_rt [4];

  lirq_router dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_level(src_level), .irq_pending(irq_pending), .cpu_irq(cpu_irq),
    .first_idx(first_idx), .first_vld(first_vld)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: run hung (actual timeout, expected finish)");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] code_of(input int s);
    int k;
    k = 31 - s;
    return m_rt[k / 8][(7 - (k % 8)) * 4 +: 4];
  endfunction

  function automatic logic [5:0] exp_cpu(input logic [31:0] p);
    logic [5:0] c;
    c = '0;
    for (int s = 0; s < 32; s++) begin
      if (p[s] && code_of(s) >= 4'd1 && code_of(s) <= 4'd6) c[code_of(s) - 4'd1] = 1'b1;
    end
    return c;
  endfunction

  function automatic logic [5:0] exp_first(input logic [31:0] p);
    for (int s = 0; s < 32; s++) begin
      if (p[s]) return {1'b1, 5'(s)};
    end
    return 6'd0;
  endfunction

  task automatic check_outputs(input string tag);
    logic [31:0] p;
    logic [5:0]  f;
    p = m_mask & src_level;
    f = exp_first(p);
    chk({tag, " R5 pending"}, irq_pending, p);
    chk({tag, " R6/R7 cpu_irq"}, {26'd0, cpu_irq}, {26'd0, exp_cpu(p)});
    chk({tag, " R8 first"}, {26'd0, first_vld, first_idx}, {26'd0, f});
  endtask

  // Access driven at negedge, sampled by one posedge, released at next negedge
  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    if (a == 8'h00) m_mask = d;
    else if (a == 8'h08) m_rt[0] = d;
    else if (a == 8'h0C) m_rt[1] = d;
    else if (a == 8'h10) m_rt[2] = d;
    else if (a == 8'h14) m_rt[3] = d;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  initial begin
    logic [31:0] rd;
    logic [31:0] lvl_at_edge;
    n_run = 0; n_fail = 0;
    m_mask = '0;
    for (int r = 0; r < 4; r++) m_rt[r] = '0;
    bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    src_level = 32'hFFFF_FFFF;
    rst_n = 1'b0;
    void'($urandom(32'h1234_5678));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 pending", irq_pending, 32'd0);
    chk("R1 cpu_irq", {26'd0, cpu_irq}, 32'd0);
    chk("R1 first_vld", {31'd0, first_vld}, 32'd0);
    chk("R1 rdata", bus_rdata, 32'd0);
    bus_read(8'h00, rd); chk("R1 mask", rd, 32'd0);
    for (int r = 0; r < 4; r++) begin
      bus_read(8'(8 + 4 * r), rd); chk("R1 route", rd, 32'd0);
    end

    // R2: mask read/write
    bus_write(8'h00, 32'hA5A5_0F0F);
    bus_read(8'h00, rd); chk("R2 mask rw", rd, 32'hA5A5_0F0F);

    // R3: status reflects level, write ignored
    src_level = 32'h1357_9BDF;
    bus_read(8'h04, rd); chk("R3 status", rd, 32'h1357_9BDF);
    bus_write(8'h04, 32'hFFFF_FFFF);
    bus_read(8'h04, rd); chk("R3 status write ignored", rd, 32'h1357_9BDF);
    bus_read(8'h00, rd); chk("R3 mask after status write", rd, 32'hA5A5_0F0F);

    // R4: field layout at the corners
    bus_write(8'h00, 32'hFFFF_FFFF);
    bus_write(8'h08, 32'h1000_0000);   // source 31 -> code 1
    src_level = 32'h8000_0000; @(negedge clk);
    chk("R4 src31 field", {26'd0, cpu_irq}, 32'h01);
    bus_write(8'h08, 32'h0000_0002);   // source 24 -> code 2
    src_level = 32'h0100_0000; @(negedge clk);
    chk("R4 src24 field", {26'd0, cpu_irq}, 32'h02);
    bus_write(8'h0C, 32'h3000_0000);   // source 23 -> code 3
    src_level = 32'h0080_0000; @(negedge clk);
    chk("R4 src23 field", {26'd0, cpu_irq}, 32'h04);
    bus_write(8'h14, 32'h0000_0006);   // source 0 -> code 6
    src_level = 32'h0000_0001; @(negedge clk);
    chk("R4 src0 field", {26'd0, cpu_irq}, 32'h20);
    bus_read(8'h14, rd); chk("R4 route rw", rd, 32'h0000_0006);

    // R7: codes 0, 7 and 15 drive nothing
    bus_write(8'h14, 32'h0000_0007); @(negedge clk);
    chk("R7 code 7", {26'd0, cpu_irq}, 32'd0);
    bus_write(8'h14, 32'h0000_000F); @(negedge clk);
    chk("R7 code 15", {26'd0, cpu_irq}, 32'd0);
    bus_write(8'h14, 32'h0000_0000); @(negedge clk);
    chk("R7 code 0", {26'd0, cpu_irq}, 32'd0);

    // R5: level sensitive, masking removes
    bus_write(8'h14, 32'h0000_0001);
    src_level = 32'h0000_0001; @(negedge clk);
    chk("R5 held level", {26'd0, cpu_irq}, 32'h01);
    bus_write(8'h00, 32'hFFFF_FFFE);
    chk("R5 masked out", irq_pending, 32'd0);
    chk("R5 masked cpu", {26'd0, cpu_irq}, 32'd0);
    bus_write(8'h00, 32'hFFFF_FFFF);
    src_level = 32'd0; @(negedge clk);
    chk("R5 level drop", irq_pending, 32'd0);

    // R8: lowest index and empty case
    src_level = 32'h8000_0000; @(negedge clk);
    chk("R8 top only", {26'd0, first_vld, first_idx}, {26'd0, 1'b1, 5'd31});
    src_level = 32'h8001_0100; @(negedge clk);
    chk("R8 lowest of three", {26'd0, first_vld, first_idx}, {26'd0, 1'b1, 5'd8});
    src_level = 32'd0; @(negedge clk);
    chk("R8 none", {31'd0, first_vld}, 32'd0);

    // R9: unmapped and unaligned offsets
    bus_read(8'h18, rd); chk("R9 unmapped 0x18", rd, 32'd0);
    bus_read(8'h02, rd); chk("R9 unaligned 0x02", rd, 32'd0);
    bus_write(8'h20, 32'h0);
    bus_write(8'h01, 32'h0);
    bus_read(8'h00, rd); chk("R9 write ignored mask", rd, 32'hFFFF_FFFF);
    bus_read(8'h14, rd); chk("R9 write ignored route", rd, 32'h0000_0001);

    // R10: registered read data holds between reads
    bus_read(8'h14, rd);
    src_level = 32'h5555_5555;
    repeat (3) @(negedge clk);
    chk("R10 rdata holds", bus_rdata, 32'h0000_0001);

    // Random mix: level changes land on the same edge as accesses
    for (int it = 0; it < 600; it++) begin
      int op;
      op = int'($urandom % 4);
      src_level = $urandom;
      if (op == 0) begin
        bus_write(8'h00, $urandom);
      end else if (op == 1) begin
        bus_write(8'(8 + 4 * ($urandom % 4)), $urandom);
      end else if (op == 2) begin
        lvl_at_edge = src_level;
        bus_read(8'h04, rd);
        chk("R3 status same edge", rd, lvl_at_edge);
        src_level = $urandom;
        @(negedge clk);
      end else begin
        bus_read(8'h00, rd);
        chk("R2 random mask", rd, m_mask);
      end
      check_outputs("rand");
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule